// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a slow crystal count (nominally 32,768 input counts per second) into a one-count-per-second tick. Every input count arrives as a single-cycle enable on the system clock. The divider has two parts: a fine stage of 256 counts, and a coarse stage that counts fine-stage periods up to a second. Drift correction happens inside this divider. Within a repeating cycle of 64 minutes, the first second of some minutes is made shorter or longer by a fixed number of input counts. A 5-bit magnitude sets how many minutes are corrected, and a direction bit sets whether the clock speeds up or slows down.

A separate divider drives a 512 Hz square wave for production measurement. That wave is gated by a small set of enable conditions and never changes with the correction setting. The block also emits a minute pulse that marks the schedule boundary. Dropping the run input clears the whole chain, and counting starts again at minute 0 of the cycle.

Top module: `cal_prescaler`

## Requirements
- R1: With magnitude 0, `tick_1hz` pulses once every STEPS*2^PRE_W input counts (32,768 by default), during the enabled count that completes the second.
- R2: With direction 1 (speed up), a corrected second lasts 2^(PRE_W-1) fewer input counts (128 fewer by default), taken from its first fine-stage period.
- R3: With direction 0 (slow down), a corrected second lasts 2^PRE_W more input counts (256 more by default), added as one extra fine-stage period.
- R4: A magnitude N corrects only the first second of minutes 0 to 2N-1 of the cycle. No other second is corrected, so the last two minutes of the cycle are never touched.
- R5: `minute_tick` pulses together with `tick_1hz` on the last second of each minute. The cycle has 2^(MAG_W+1) minutes (64 by default) and then restarts at minute 0.
- R6: Magnitude and direction are captured when a minute starts, or while the divider is stopped. A change in the middle of a minute has no effect until the next minute.
- R7: While `osc_run` is low, the divider, the second position, the minute position and the test divider are all held at zero. After `osc_run` rises, counting begins at minute 0, second 0.
- R8: When enabled, `test_wave` is a square wave with a period of 2^TEST_W input counts (512 Hz by default). It is low for the first half of each period after a restart and does not depend on the correction setting.
- R9: `test_wave` is forced low unless all of these hold: `osc_run` is high, `freq_test_en` is 1, `alarm_flag_en` is 0, and either `wdog_steer` is 1 or `wdog_reg_zero` is 1.
- R10: Clock cycles without `osc_en` advance no counter, produce no tick, and leave `test_wave` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_run | input | 1 | Oscillator running; low clears and holds the chain |
| osc_en | input | 1 | One input count, single-cycle enable |
| cal_mag | input | MAG_W | Correction magnitude |
| cal_pos | input | 1 | Correction direction, 1 = speed up, 0 = slow down |
| freq_test_en | input | 1 | Test-wave request |
| alarm_flag_en | input | 1 | Alarm interrupt enable, blocks the test wave |
| wdog_steer | input | 1 | Watchdog steering bit |
| wdog_reg_zero | input | 1 | Watchdog register holds zero |
| tick_1hz | output | 1 | One-cycle pulse at the end of each second |
| minute_tick | output | 1 | One-cycle pulse at the end of each minute |
| test_wave | output | 1 | Gated 512 Hz square wave |

## Verification
Two events can land on the same input count: the end of a minute, which is also the moment the new magnitude is captured, and the start of a corrected second. The bench provokes this by changing the magnitude and direction at minute boundaries, in the middle of a second and across a restart. It measures every second's length in input counts against a model that captures the setting at each minute end. In parallel it checks the test wave count by count while the corrected seconds run, to confirm that correction never disturbs the wave.

// File: rtl/cpre_pkg.sv
package cpre_pkg;

  // Length in input counts of one fine-stage period, full or shortened.
  function automatic int unsigned stage_period(int unsigned prew, logic shortened);
    return shortened ? (32'd1 << (prew - 1)) : (32'd1 << prew);
  endfunction

  // A minute lies inside the correction window when it precedes 2*mag.
  function automatic logic in_window(int unsigned minute, int unsigned mag);
    return minute < (2 * mag);
  endfunction

endpackage

// File: rtl/cpre_stage.sv
module cpre_stage #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             shorten,
  output logic             stage_tick
);
  import cpre_pkg::*;

  logic [PRE_W-1:0] lo_q;
  logic [PRE_W-1:0] lo_last;

  assign lo_last    = PRE_W'(stage_period(PRE_W, shorten) - 1);
  assign stage_tick = en && (lo_q == lo_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_q <= '0;
    else if (clr)        lo_q <= '0;
    else if (stage_tick) lo_q <= '0;
    else if (en)         lo_q <= lo_q + 1'b1;
  end

  // R10: idle cycles leave the fine stage untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(lo_q));

endmodule

// File: rtl/cpre_secmin.sv
module cpre_secmin #(
  parameter int STEPS = 128,
  parameter int SPM   = 60,
  parameter int MIN_W = 6,
  localparam int STEP_W = $clog2(STEPS + 1),
  localparam int SEC_W  = (SPM > 1) ? $clog2(SPM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stage_tick,
  input  logic              extend,
  output logic [STEP_W-1:0] step_idx,
  output logic [SEC_W-1:0]  sec_idx,
  output logic [MIN_W-1:0]  min_idx,
  output logic              sec_tick,
  output logic              min_tick
);
  localparam logic [MIN_W-1:0] MIN_LAST = '1;

  logic [STEP_W-1:0] step_last;

  assign step_last = STEP_W'(STEPS - 1) + STEP_W'(extend);
  assign sec_tick  = stage_tick && (step_idx == step_last);
  assign min_tick  = sec_tick && (sec_idx == SEC_W'(SPM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_idx <= '0;
      sec_idx  <= '0;
      min_idx  <= '0;
    end else if (clr) begin
      step_idx <= '0;
      sec_idx  <= '0;
      min_idx  <= '0;
    end else if (stage_tick) begin
      if (sec_tick) begin
        step_idx <= '0;
        if (min_tick) begin
          sec_idx <= '0;
          min_idx <= (min_idx == MIN_LAST) ? '0 : min_idx + 1'b1;
        end else begin
          sec_idx <= sec_idx + 1'b1;
        end
      end else begin
        step_idx <= step_idx + 1'b1;
      end
    end
  end

  // R5: the last minute of the cycle is followed by minute 0
  p_cycle_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && (min_idx == MIN_LAST)) |=> (min_idx == '0));

  // R7: a stopped oscillator leaves the whole position at zero
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (step_idx == '0 && sec_idx == '0 && min_idx == '0));

endmodule

// File: rtl/cpre_sched.sv
module cpre_sched #(
  parameter int MAG_W  = 5,
  parameter int STEP_W = 8,
  parameter int SEC_W  = 6,
  localparam int MIN_W = MAG_W + 1,
  localparam int MINS  = 1 << MIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              min_tick,
  input  logic [MAG_W-1:0]  cal_mag,
  input  logic              cal_pos,
  input  logic [STEP_W-1:0] step_idx,
  input  logic [SEC_W-1:0]  sec_idx,
  input  logic [MIN_W-1:0]  min_idx,
  output logic              shorten,
  output logic              extend
);
  import cpre_pkg::*;

  logic [MAG_W-1:0] mag_lat;
  logic             pos_lat;
  logic             corr_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_lat <= '0;
      pos_lat <= 1'b0;
    end else if (clr || min_tick) begin
      mag_lat <= cal_mag;
      pos_lat <= cal_pos;
    end
  end

  assign corr_sec = (sec_idx == '0) && in_window(int'(min_idx), int'(mag_lat));
  assign shorten  = corr_sec && pos_lat && (step_idx == '0);
  assign extend   = corr_sec && !pos_lat;

  // R4: the final two minutes of the cycle are never corrected
  p_window_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shorten || extend) |-> (min_idx < MIN_W'(MINS - 2)));

  // R6: the captured setting only moves at a minute start or while stopped
  p_setting_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !min_tick) |=> ($stable(mag_lat) && $stable(pos_lat)));

endmodule

// File: rtl/cpre_testout.sv
module cpre_testout #(
  parameter int TEST_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic allow,
  output logic test_wave
);
  logic [TEST_W-1:0] tdiv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tdiv_q <= '0;
    else if (clr) tdiv_q <= '0;
    else if (en)  tdiv_q <= tdiv_q + 1'b1;
  end

  assign test_wave = allow && tdiv_q[TEST_W-1];

  // R8: the test divider advances exactly once per input count
  p_test_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (tdiv_q == $past(tdiv_q) + 1'b1));

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRE_W  = 8,
  parameter int STEPS  = 128,
  parameter int SPM    = 60,
  parameter int MAG_W  = 5,
  parameter int TEST_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_run,
  input  logic             osc_en,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  input  logic             freq_test_en,
  input  logic             alarm_flag_en,
  input  logic             wdog_steer,
  input  logic             wdog_reg_zero,
  output logic             tick_1hz,
  output logic             minute_tick,
  output logic             test_wave
);
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam int SEC_W  = (SPM > 1) ? $clog2(SPM) : 1;
  localparam int MIN_W  = MAG_W + 1;

  logic              clr;
  logic              stage_tick;
  logic              shorten;
  logic              extend;
  logic              test_allow;
  logic [STEP_W-1:0] step_idx;
  logic [SEC_W-1:0]  sec_idx;
  logic [MIN_W-1:0]  min_idx;

  assign clr        = !osc_run;
  assign test_allow = osc_run && freq_test_en && !alarm_flag_en && (wdog_steer || wdog_reg_zero);

  cpre_stage #(.PRE_W(PRE_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(osc_en),
    .shorten(shorten), .stage_tick(stage_tick)
  );

  cpre_secmin #(.STEPS(STEPS), .SPM(SPM), .MIN_W(MIN_W)) secmin_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stage_tick(stage_tick), .extend(extend),
    .step_idx(step_idx), .sec_idx(sec_idx), .min_idx(min_idx),
    .sec_tick(tick_1hz), .min_tick(minute_tick)
  );

  cpre_sched #(.MAG_W(MAG_W), .STEP_W(STEP_W), .SEC_W(SEC_W)) sched_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .min_tick(minute_tick),
    .cal_mag(cal_mag), .cal_pos(cal_pos),
    .step_idx(step_idx), .sec_idx(sec_idx), .min_idx(min_idx),
    .shorten(shorten), .extend(extend)
  );

  cpre_testout #(.TEST_W(TEST_W)) test_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(osc_en),
    .allow(test_allow), .test_wave(test_wave)
  );

  // R1: a second can only end on an input count
  p_tick_on_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> osc_en);

  // R3: a slowed second never ends on its regular final step
  p_no_early_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (extend && stage_tick && step_idx == STEP_W'(STEPS - 1)) |-> !tick_1hz);

endmodule

// File: tb/cal_prescaler_tb_top.sv
module cal_prescaler_tb_top;
  localparam int PRE_W  = 3;
  localparam int STEPS  = 4;
  localparam int SPM    = 3;
  localparam int MAG_W  = 2;
  localparam int TEST_W = 3;
  localparam int MINS   = 1 << (MAG_W + 1);
  localparam int NORM   = STEPS << PRE_W;
  localparam int SHORT  = NORM - (1 << (PRE_W - 1));
  localparam int LONG   = NORM + (1 << PRE_W);
  localparam int TPER   = 1 << TEST_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_run = 1'b0, osc_en = 1'b0;
  logic [MAG_W-1:0] cal_mag = '0;
  logic cal_pos = 1'b0;
  logic freq_test_en = 1'b0, alarm_flag_en = 1'b0, wdog_steer = 1'b0, wdog_reg_zero = 1'b0;
  logic tick_1hz, minute_tick, test_wave;

  int checks = 0, errors = 0;
  logic s_sec, s_min, s_tq;
  int pc = 0;
  bit tchk = 0;
  int bm = 0, bs = 0, lat_mag = 0;
  bit lat_pos = 0;

  always #5 clk = ~clk;

  cal_prescaler #(.PRE_W(PRE_W), .STEPS(STEPS), .SPM(SPM), .MAG_W(MAG_W), .TEST_W(TEST_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_run(osc_run), .osc_en(osc_en),
    .cal_mag(cal_mag), .cal_pos(cal_pos), .freq_test_en(freq_test_en),
    .alarm_flag_en(alarm_flag_en), .wdog_steer(wdog_steer), .wdog_reg_zero(wdog_reg_zero),
    .tick_1hz(tick_1hz), .minute_tick(minute_tick), .test_wave(test_wave)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive the count enable, sample outputs before the next edge.
  task automatic tick(input logic en);
    @(negedge clk);
    osc_en = en;
    #2;
    s_sec = tick_1hz; s_min = minute_tick; s_tq = test_wave;
    if (en) begin
      if (tchk) chk("R8 test wave", int'(s_tq), int'((pc % TPER) >= TPER / 2));
      pc++;
    end
  endtask

  task automatic restart();
    osc_run = 1'b0;
    tick(0); tick(0);
    osc_run = 1'b1;
    pc = 0; bm = 0; bs = 0;
    lat_mag = int'(cal_mag); lat_pos = cal_pos;
  endtask

  // Measure one second; optionally change the setting after chg_at counts.
  task automatic run_one(input string req, input int chg_at, input int nm, input bit np);
    int len = 0;
    int exp_len;
    bit last;
    exp_len = (bs == 0 && bm < 2 * lat_mag) ? (lat_pos ? SHORT : LONG) : NORM;
    last = (bs == SPM - 1);
    do begin
      if (len == chg_at) begin cal_mag = MAG_W'(nm); cal_pos = np; end
      tick(1);
      len++;
    end while (!s_sec && len < 200);
    chk(req, len, exp_len);
    chk("R5 minute pulse", int'(s_min), int'(last));
    if (last) begin
      bs = 0; bm = (bm + 1) % MINS;
      lat_mag = int'(cal_mag); lat_pos = cal_pos;
    end else bs++;
  endtask

  task automatic set_test(input logic ft, input logic afe, input logic st, input logic wz);
    freq_test_en = ft; alarm_flag_en = afe; wdog_steer = st; wdog_reg_zero = wz;
  endtask

  task automatic t_reset();
    tick(0);
    chk("R7 reset tick", int'(s_sec), 0);
    chk("R7 reset minute", int'(s_min), 0);
    chk("R9 reset wave", int'(s_tq), 0);
  endtask

  task automatic t_nominal();
    cal_mag = 0; cal_pos = 0; set_test(1, 0, 1, 0); tchk = 1;
    restart();
    for (int i = 0; i < 2 * SPM * MINS; i++) run_one("R1 nominal", -1, 0, 0);
    tchk = 0;
  endtask

  task automatic t_pos();
    cal_mag = 3; cal_pos = 1; set_test(1, 0, 1, 0); tchk = 1;
    restart();
    for (int i = 0; i < SPM * MINS; i++) run_one("R2 R4 speed-up", -1, 0, 0);
    tchk = 0;
  endtask

  task automatic t_neg();
    cal_mag = 1; cal_pos = 0; set_test(1, 0, 0, 1); tchk = 1;
    restart();
    for (int i = 0; i < SPM * MINS + SPM * 2; i++) run_one("R3 R4 slow-down", -1, 0, 0);
    tchk = 0;
  endtask

  task automatic t_latch();
    cal_mag = 1; cal_pos = 0;
    restart();
    run_one("R6 mid-second drop", 5, 0, 0);
    for (int i = 0; i < SPM; i++) run_one("R6 next minute", -1, 0, 0);
    cal_mag = 0; cal_pos = 1;
    restart();
    run_one("R6 mid-second raise", 3, 1, 1);
    run_one("R6 mid-minute", 4, 2, 0);
    for (int i = 0; i < SPM * 2; i++) run_one("R6 applied", -1, 0, 0);
  endtask

  task automatic t_restart();
    cal_mag = 0; cal_pos = 0;
    restart();
    for (int i = 0; i < SPM + 1; i++) run_one("R7 pre-stop", -1, 0, 0);
    for (int i = 0; i < 10; i++) tick(1);
    cal_mag = 1; cal_pos = 1;
    restart();
    for (int i = 0; i < SPM + 1; i++) run_one("R7 after restart", -1, 0, 0);
  endtask

  task automatic gate_case(input logic ft, input logic afe, input logic st, input logic wz, input int exp);
    set_test(ft, afe, st, wz);
    restart();
    for (int i = 0; i < TPER / 2; i++) tick(1);
    tick(0);
    chk("R9 gate", int'(s_tq), exp);
  endtask

  task automatic t_gate();
    cal_mag = 0; cal_pos = 0;
    gate_case(1, 0, 1, 0, 1);
    gate_case(1, 0, 0, 1, 1);
    gate_case(0, 0, 1, 1, 0);
    gate_case(1, 1, 1, 1, 0);
    gate_case(1, 0, 0, 0, 0);
  endtask

  task automatic t_hold();
    logic held;
    int seen = 0;
    cal_mag = 0; cal_pos = 0; set_test(1, 0, 1, 0);
    restart();
    for (int i = 0; i < TPER / 2 + 2; i++) tick(1);
    tick(0);
    held = s_tq;
    for (int i = 0; i < 40; i++) begin
      tick(0);
      if (s_sec || s_tq != held) seen++;
    end
    chk("R10 idle no change", seen, 0);
    seen = 0;
    for (int i = TPER / 2 + 2; i < NORM; i++) begin
      tick(1);
      if (s_sec) seen = i + 1;
    end
    chk("R10 second after idle", seen, NORM);
  endtask

  initial begin
    #(1_500_000ns);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_pos();
    t_neg();
    t_latch();
    t_restart();
    t_gate();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule